// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the countdown timer of a per-processor interrupt controller, together with its clock prescaler. Software programs it through a small register port: a timer table entry (mask bit, periodic/one-shot selector, 8-bit vector), a divide configuration, an initial count, and a read-only current count. Writing the initial count starts a new count. The block counts prescaled clock ticks from that write, and whenever a period of (initial count + 1) ticks completes, it issues a single-cycle interrupt request that carries the programmed vector.

The prescaler divides the clock by a power of two chosen from the divide configuration. In periodic mode the request repeats at every multiple of the period. In one-shot mode it fires once and then stays idle until the initial count is written again. The mask bit silences every request but does not stop counting. An initial count of zero turns the timer off in both modes.

Top module: `local_int_timer`

## Requirements
- R1: After reset the table entry reads 0x0001_0000 (masked, one-shot, vector 0), the divide configuration reads 0, the initial and current counts read 0, and `irq_pulse` is low.
- R2: Registers are selected by a 2-bit address: 0 = table entry (bit 17 periodic, bit 16 mask, bits 7:0 vector; every other bit reads 0), 1 = divide configuration (bits 3:0), 2 = initial count, 3 = current count. A write to address 3 has no effect.
- R3: The divide code is {cfg[3], cfg[1], cfg[0]}, and cfg[2] is ignored. Code 3'b111 divides by 1, and any other code n divides by 2^(n+1). From reset until the first divide write, the prescaler divides by 1.
- R4: In periodic mode with initial count I > 0 and divider D, `irq_pulse` is high exactly in the cycles that follow the k*(I+1)*D-th rising edge after the loading edge, for k = 1, 2, ....
- R5: In one-shot mode with I > 0, a single pulse follows the (I+1)*D-th edge after loading, and no pulse follows later.
- R6: An initial count of zero never produces a pulse, in either mode.
- R7: While the mask bit is set, no pulse is produced. Counting continues: a one-shot boundary passed while masked is used up, and a periodic timer that is unmasked again fires at the next multiple of its period.
- R8: Every pulse lasts one cycle, and `irq_vector` then equals bits 7:0 of the table entry at the boundary.
- R9: The current count reads I minus the prescaled ticks elapsed in the current period. It reads 0 after a one-shot has expired and while the timer is idle.
- R10: Writing the initial count restarts counting from that edge. A period boundary that falls on that same edge produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
A write to the initial count can land on the very edge where a period boundary would fire. These two events must resolve in favour of the restart. The bench provokes the collision by timing a reload write so that its edge is exactly the (I+1)*D-th edge after the previous load. It then requires that no pulse follows that edge and that the next pulse follows (I'+1)*D edges after the reload. A second collision, a boundary passing while the mask is set, is judged by the pulse count staying flat and by the next periodic pulse landing on a multiple of the original period.

// File: rtl/lit_pkg.sv
package lit_pkg;

  localparam int VEC_W        = 8;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;

  typedef enum logic [1:0] {
    ADDR_ENTRY = 2'd0,
    ADDR_DIV   = 2'd1,
    ADDR_INIT  = 2'd2,
    ADDR_CUR   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // Divide configuration to shift amount: code {b3,b1,b0}, 7 -> 0, n -> n+1.
  function automatic logic [3:0] div_shift(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return (code == 3'b111) ? 4'd0 : ({1'b0, code} + 4'd1);
  endfunction

  // Last prescaler count value before a tick for a given shift.
  function automatic logic [31:0] div_last(input logic [3:0] sh);
    return (32'd1 << sh) - 32'd1;
  endfunction

  function automatic logic [31:0] pack_entry(input entry_t e);
    logic [31:0] w;
    w = '0;
    w[PERIODIC_BIT] = e.periodic;
    w[MASK_BIT]     = e.mask;
    w[VEC_W-1:0]    = e.vec;
    return w;
  endfunction

endpackage

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output entry_t           entry,
  output logic [3:0]       div_cfg,
  output logic [3:0]       shift,
  output logic [CNT_W-1:0] init_cnt,
  output logic             reload
);

  logic wr_entry, wr_div;

  assign wr_entry = wr_en && (wr_addr == ADDR_ENTRY);
  assign wr_div   = wr_en && (wr_addr == ADDR_DIV);
  assign reload   = wr_en && (wr_addr == ADDR_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry.periodic <= 1'b0;
      entry.mask     <= 1'b1;
      entry.vec      <= '0;
      div_cfg        <= '0;
      shift          <= '0;
      init_cnt       <= '0;
    end else begin
      if (wr_entry) begin
        entry.periodic <= wr_data[PERIODIC_BIT];
        entry.mask     <= wr_data[MASK_BIT];
        entry.vec      <= wr_data[VEC_W-1:0];
      end
      if (wr_div) begin
        div_cfg <= wr_data[3:0];
        shift   <= div_shift(wr_data[3:0]);
      end
      if (reload) init_cnt <= CNT_W'(wr_data);
    end
  end

  assert_shift_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (shift == div_shift($past(wr_data[3:0]))));

endmodule

// File: rtl/lit_prescale.sv
module lit_prescale
  import lit_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [3:0] shift,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last;

  assign last = PRE_W'(div_last(shift));
  assign tick = (pcnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (tick)    pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt == '0));

endmodule

// File: rtl/lit_period.sv
module lit_period #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic             periodic,
  input  logic             mask,
  output logic             boundary,
  output logic             fire,
  output logic [CNT_W-1:0] remaining
);

  logic [CNT_W-1:0] tcnt;
  logic             armed;
  logic             at_end;

  function automatic logic [CNT_W-1:0] left(input logic [CNT_W-1:0] i,
                                            input logic [CNT_W-1:0] t,
                                            input logic             a);
    return a ? (i - t) : '0;
  endfunction

  assign at_end    = (tcnt == init_cnt);
  assign boundary  = tick && armed && at_end && !reload;
  assign fire      = boundary && (init_cnt != '0) && !mask;
  assign remaining = left(init_cnt, tcnt, armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      armed <= 1'b0;
    end else if (reload) begin
      tcnt  <= '0;
      armed <= 1'b1;
    end else if (tick && armed) begin
      if (at_end) begin
        tcnt <= '0;
        if (!periodic) armed <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assert_oneshot_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !periodic) |=> !armed);

  assert_reload_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (armed && tcnt == '0));

endmodule

// File: rtl/local_int_timer.sv
module local_int_timer
  import lit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);

  entry_t           entry;
  logic [3:0]       div_cfg;
  logic [3:0]       shift;
  logic [CNT_W-1:0] init_cnt;
  logic             reload;
  logic             tick;
  logic             boundary;
  logic             fire;
  logic [CNT_W-1:0] remaining;

  lit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .entry(entry), .div_cfg(div_cfg), .shift(shift),
    .init_cnt(init_cnt), .reload(reload)
  );

  lit_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(reload), .shift(shift), .tick(tick)
  );

  lit_period #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .reload(reload), .tick(tick),
    .init_cnt(init_cnt), .periodic(entry.periodic), .mask(entry.mask),
    .boundary(boundary), .fire(fire), .remaining(remaining)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_ENTRY: rd_data = pack_entry(entry);
      ADDR_DIV:   rd_data = {28'd0, div_cfg};
      ADDR_INIT:  rd_data = 32'(init_cnt);
      default:    rd_data = 32'(remaining);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= fire;
      if (fire) irq_vector <= entry.vec;
    end
  end

  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(entry.mask));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_vector == $past(entry.vec)));

  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(init_cnt) != '0));

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= init_cnt);

endmodule

// File: tb/local_int_timer_tb.sv
module local_int_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pcount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  local_int_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && irq_pulse) pcount <= pcount + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Assumes the caller stands at a falling edge; returns at the next one.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic int divider(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return (code == 3'b111) ? 1 : (2 << code);
  endfunction

  function automatic logic [31:0] entry_word(input bit per, input bit msk, input logic [7:0] v);
    return (per ? 32'h0002_0000 : 32'h0) | (msk ? 32'h0001_0000 : 32'h0) | {24'd0, v};
  endfunction

  // Runs one configuration and compares every cycle of the window.
  task automatic run_cfg(input logic [3:0] cfg, input int init, input bit per, input logic [7:0] v);
    int d, n, L, bad_p, bad_c, bad_v, win;
    logic [31:0] r;
    d = divider(cfg);
    n = (init + 1) * d;
    wr(2'd2, 32'd0);
    wr(2'd1, {28'd0, cfg});
    wr(2'd0, entry_word(per, 1'b0, v));
    wr(2'd2, init);
    L = cyc;
    bad_p = 0; bad_c = 0; bad_v = 0;
    win = per ? 2 * n + 2 : 3 * n;
    for (int c = 1; c <= win; c++) begin
      logic       ep;
      int         ec;
      @(negedge clk);
      ep = per ? (c % n == 0) : (c == n);
      if (per)         ec = init - ((c / d) % (init + 1));
      else if (c >= n) ec = 0;
      else             ec = init - (c / d);
      rd(2'd3, r);
      if (irq_pulse !== ep) bad_p++;
      if (r !== 32'(ec)) bad_c++;
      if (irq_pulse && irq_vector !== v) bad_v++;
      if (cyc != L + c) bad_p++;
    end
    if (per) chk("R4 periodic pulse pattern mismatches", bad_p, 0);
    else     chk("R5 one-shot pulse pattern mismatches", bad_p, 0);
    chk("R9 current count mismatches", bad_c, 0);
    chk("R8 vector mismatches", bad_v, 0);
  endtask

  initial begin
    logic [31:0] r;
    int L, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk("R1 entry reset", r, 32'h0001_0000);
    rd(2'd1, r); chk("R1 divide reset", r, 32'h0);
    rd(2'd2, r); chk("R1 initial reset", r, 32'h0);
    rd(2'd3, r); chk("R1 current reset", r, 32'h0);
    chk("R1 no pulse", irq_pulse, 1'b0);

    // R2 register map and field masking
    wr(2'd3, 32'h55);
    rd(2'd3, r); chk("R2 current ignores write", r, 32'h0);
    rd(2'd2, r); chk("R2 initial untouched", r, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R2 entry fields", r, 32'h0003_00FF);

    // R3 divide by 1 before any divide write: I=2 -> pulse after 3 edges
    wr(2'd0, entry_word(1'b1, 1'b0, 8'h31));
    wr(2'd2, 32'd2);
    L = cyc;
    wait_to(L + 2); chk("R3 default divide, no early pulse", irq_pulse, 1'b0);
    wait_to(L + 3); chk("R3 default divide by 1 pulse", irq_pulse, 1'b1);
    chk("R8 default vector", irq_vector, 8'h31);
    wr(2'd1, 32'hF);
    rd(2'd1, r); chk("R2 divide readback", r, 32'hF);

    // R3/R4/R5/R9 sweep: all codes, bit 2 toggled to show it is ignored
    for (int code = 0; code < 8; code++) begin
      logic [3:0] cfg;
      cfg = {code[2], code[0] ^ code[1], code[1], code[0]};
      for (int i = 1; i <= 3; i++)
        run_cfg(cfg, i, 1'b1, 8'(8'h40 + code * 4 + i));
      run_cfg(cfg, 2, 1'b0, 8'(8'h80 + code));
    end

    // R6 zero count, both modes
    wr(2'd1, 32'hB);
    wr(2'd0, entry_word(1'b1, 1'b0, 8'h11));
    p0 = pcount;
    wr(2'd2, 32'd0);
    repeat (40) @(negedge clk);
    rd(2'd3, r); chk("R6 periodic zero current", r, 32'h0);
    wr(2'd0, entry_word(1'b0, 1'b0, 8'h12));
    wr(2'd2, 32'd0);
    repeat (40) @(negedge clk);
    chk("R6 zero count pulses", pcount - p0, 0);

    // R7 periodic masked: I=3, D=2, N=8
    wr(2'd1, 32'h0);
    wr(2'd0, entry_word(1'b1, 1'b1, 8'h21));
    p0 = pcount;
    wr(2'd2, 32'd3);
    L = cyc;
    wait_to(L + 18);
    chk("R7 masked periodic silent", pcount - p0, 0);
    wr(2'd0, entry_word(1'b1, 1'b0, 8'h22));
    wait_to(L + 23); chk("R7 no pulse before multiple", irq_pulse, 1'b0);
    wait_to(L + 24); chk("R7 unmasked resumes at multiple", irq_pulse, 1'b1);
    chk("R8 vector after unmask", irq_vector, 8'h22);

    // R7 one-shot boundary consumed while masked: I=1, D=1
    wr(2'd1, 32'hB);
    wr(2'd0, entry_word(1'b0, 1'b1, 8'h23));
    wr(2'd2, 32'd1);
    repeat (6) @(negedge clk);
    p0 = pcount;
    wr(2'd0, entry_word(1'b0, 1'b0, 8'h23));
    repeat (12) @(negedge clk);
    chk("R7 one-shot consumed while masked", pcount - p0, 0);
    rd(2'd3, r); chk("R9 expired one-shot reads zero", r, 32'h0);

    // R10 reload on the boundary edge: I=3, D=1, N=4; reload to I=5
    wr(2'd0, entry_word(1'b1, 1'b0, 8'h24));
    wr(2'd2, 32'd3);
    L = cyc;
    wait_to(L + 3);
    p0 = pcount;
    wr(2'd2, 32'd5);
    chk("R10 boundary on reload edge suppressed", irq_pulse, 1'b0);
    wait_to(L + 9); chk("R10 no pulse before new period", pcount - p0, 0);
    wait_to(L + 10); chk("R10 pulse after restart", irq_pulse, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule